// File: doc/BRIEF.md
# Streamed Pixel Frame Buffer Loader

This block keeps one grayscale image in a buffer that two agents share. A writer state machine takes pixel-update records from a first-word-fall-through queue that has already been moved into the inference clock domain. Each record holds a pixel address and a pixel value. The writer stores the value in the frame buffer. At the same time, the inference engine reads the buffer through its own port. Writes never stall those reads, so one pass of the engine may see a mix of old and new pixels.

The block also gates the engine's prediction results toward a downstream result queue. The engine produces results all the time. When the queue reports full, the result is dropped and nothing is pushed. The queues themselves are outside this block.

Top module: `pix_frame_loader`

## Requirements
- R1: After reset, all 784 pixel locations read as 0 and the writer is polling, with `upd_rd_o` = 1.
- R2: While polling, the writer holds `upd_rd_o` high every cycle. A record is consumed at a rising edge where `upd_valid_i` and `upd_rd_o` are both high.
- R3: A consumed record with an address from 0 to 783 is followed by exactly one store cycle in which `upd_rd_o` is low. Its value is in the buffer from the end of that cycle, and `upd_rd_o` is high again in the next cycle.
- R4: A consumed record with an address from 784 to 1023 is discarded. No location changes, and `upd_rd_o` stays high in the next cycle.
- R5: `rd_data_o` presents the pixel at the `rd_addr_i` value sampled at the previous rising edge, a latency of one cycle. Reads are served in every cycle, whatever the writer is doing.
- R6: A read of the location being stored in the same cycle returns the old value. The read after it returns the new value.
- R7: A read address from 784 to 1023 returns 0 after one cycle.
- R8: `pred_push_o` follows `pred_valid_i` while `pred_full_i` is low, and `pred_data_o` carries `pred_i`. While `pred_full_i` is high, no push occurs and the result is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Inference-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Input queue holds a record |
| upd_addr_i | input | 10 | Pixel address of the head record |
| upd_pix_i | input | 8 | Pixel value of the head record |
| upd_rd_o | output | 1 | Read enable to the input queue |
| rd_addr_i | input | 10 | Engine read address |
| rd_data_o | output | 8 | Engine read data, registered |
| pred_valid_i | input | 1 | Engine has a prediction result |
| pred_i | input | 4 | Prediction label |
| pred_full_i | input | 1 | Result queue is full |
| pred_push_o | output | 1 | Write enable to the result queue |
| pred_data_o | output | 4 | Result written to the queue |

## Verification
Several results fall due at different times after a stimulus:
- A record is consumed at the edge that ends its offered cycle.
- The store-cycle drop of `upd_rd_o` is due one cycle after that edge.
- The stored value is due two edges after consumption.
- Read data is due one edge after the address.
- The prediction push is combinational in the same cycle.

The bench changes inputs on falling edges and samples on the next falling edge, or a short delay after the change for the combinational path. Each sample therefore lands exactly one register stage after its cause. The collision case moves the read address onto the store address during the store cycle. It then expects the old value and, one cycle later, the new value.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic {
    WR_POLL  = 1'b0,
    WR_STORE = 1'b1
  } wr_state_e;
endpackage

// File: rtl/pfl_writer.sv
module pfl_writer
  import pfl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8,
  parameter int DEPTH  = 784
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [PIX_W-1:0]  upd_pix_i,
  output logic              upd_rd_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [PIX_W-1:0]  wdata_o
);
  localparam logic [ADDR_W-1:0] DepthA = ADDR_W'(DEPTH);

  wr_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PIX_W-1:0]  pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_POLL;
      addr_q  <= '0;
      pix_q   <= '0;
    end else begin
      case (state_q)
        WR_POLL: begin
          // out-of-range records are popped and dropped, no store cycle
          if (upd_valid_i && (upd_addr_i < DepthA)) begin
            state_q <= WR_STORE;
            addr_q  <= upd_addr_i;
            pix_q   <= upd_pix_i;
          end
        end
        WR_STORE: state_q <= WR_POLL;
      endcase
    end
  end

  assign upd_rd_o = (state_q == WR_POLL);
  assign we_o     = (state_q == WR_STORE);
  assign waddr_o  = addr_q;
  assign wdata_o  = pix_q;
endmodule

// File: rtl/pfl_pixel_ram.sv
module pfl_pixel_ram #(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8,
  parameter int DEPTH  = 784
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [PIX_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [PIX_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] DepthA = ADDR_W'(DEPTH);

  logic [PIX_W-1:0] mem_q [DEPTH];

  // read-first: nonblocking read sees contents before this edge's write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i && (waddr_i < DepthA)) mem_q[waddr_i] <= wdata_i;
      rdata_o <= (raddr_i < DepthA) ? mem_q[raddr_i] : '0;
    end
  end
endmodule

// File: rtl/pfl_pred_gate.sv
module pfl_pred_gate #(
  parameter int PRED_W = 4
) (
  input  logic              valid_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [PRED_W-1:0] data_o
);
  // results stream continuously; a full queue simply loses them
  assign push_o = valid_i && !full_i;
  assign data_o = pred_i;
endmodule

// File: rtl/pix_frame_loader.sv
module pix_frame_loader #(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8,
  parameter int DEPTH  = 784,
  parameter int PRED_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [PIX_W-1:0]  upd_pix_i,
  output logic              upd_rd_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [PIX_W-1:0]  rd_data_o,
  input  logic              pred_valid_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic              pred_full_i,
  output logic              pred_push_o,
  output logic [PRED_W-1:0] pred_data_o
);
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [PIX_W-1:0]  ram_wdata;

  pfl_writer #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .DEPTH(DEPTH)) i_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_valid_i (upd_valid_i),
    .upd_addr_i  (upd_addr_i),
    .upd_pix_i   (upd_pix_i),
    .upd_rd_o    (upd_rd_o),
    .we_o        (ram_we),
    .waddr_o     (ram_waddr),
    .wdata_o     (ram_wdata)
  );

  pfl_pixel_ram #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .DEPTH(DEPTH)) i_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  pfl_pred_gate #(.PRED_W(PRED_W)) i_pred (
    .valid_i (pred_valid_i),
    .pred_i  (pred_i),
    .full_i  (pred_full_i),
    .push_o  (pred_push_o),
    .data_o  (pred_data_o)
  );
endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8,
  parameter int DEPTH  = 784,
  parameter int PRED_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_addr_i,
  input logic              upd_rd_o,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [PIX_W-1:0]  rd_data_o,
  input logic              pred_valid_i,
  input logic [PRED_W-1:0] pred_i,
  input logic              pred_full_i,
  input logic              pred_push_o,
  input logic [PRED_W-1:0] pred_data_o,
  input logic              ram_we
);
  localparam logic [ADDR_W-1:0] DepthA = ADDR_W'(DEPTH);

  a_r3_take_then_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_rd_o && upd_valid_i && (upd_addr_i < DepthA)) |=> (!upd_rd_o && ram_we));

  a_r3_single_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_rd_o |=> upd_rd_o);

  a_r4_discard_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_rd_o && upd_valid_i && (upd_addr_i >= DepthA)) |=> (upd_rd_o && !ram_we));

  a_r7_oob_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= DepthA) |=> (rd_data_o == '0));

  a_r8_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_full_i |-> !pred_push_o);

  a_r8_push_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_i && !pred_full_i) |-> (pred_push_o && (pred_data_o == pred_i)));
endmodule

bind pix_frame_loader pfl_checker #(
  .ADDR_W(ADDR_W), .PIX_W(PIX_W), .DEPTH(DEPTH), .PRED_W(PRED_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .upd_valid_i  (upd_valid_i),
  .upd_addr_i   (upd_addr_i),
  .upd_rd_o     (upd_rd_o),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .pred_valid_i (pred_valid_i),
  .pred_i       (pred_i),
  .pred_full_i  (pred_full_i),
  .pred_push_o  (pred_push_o),
  .pred_data_o  (pred_data_o),
  .ram_we       (ram_we)
);

// File: tb/test_pix_frame_loader.sv
`timescale 1ns/1ps
module test_pix_frame_loader;
  localparam int DEPTH = 784;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_valid = 1'b0;
  logic [9:0] upd_addr = '0;
  logic [7:0] upd_pix = '0;
  logic       upd_rd;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pred_valid = 1'b0;
  logic [3:0] pred = '0;
  logic       pred_full = 1'b0;
  logic       pred_push;
  logic [3:0] pred_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  pix_frame_loader i_pix_frame_loader (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .upd_valid_i  (upd_valid),
    .upd_addr_i   (upd_addr),
    .upd_pix_i    (upd_pix),
    .upd_rd_o     (upd_rd),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .pred_valid_i (pred_valid),
    .pred_i       (pred),
    .pred_full_i  (pred_full),
    .pred_push_o  (pred_push),
    .pred_data_o  (pred_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_read(input logic [9:0] a);
    return (a < 10'(DEPTH)) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic read_chk(input logic [9:0] a, input string req);
    @(negedge clk); rd_addr = a;
    @(negedge clk);
    chk(rd_data == ref_read(a), req, rd_data, ref_read(a));
  endtask

  task automatic push(input logic [9:0] a, input logic [7:0] p, input bit coll);
    logic [7:0] old;
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_pix = p;
    while (!upd_rd) @(negedge clk);
    chk(upd_rd == 1'b1, "R2", upd_rd, 1);
    old = ref_read(a);
    @(negedge clk);
    upd_valid = 1'b0;
    if (a < 10'(DEPTH)) chk(upd_rd == 1'b0, "R3", upd_rd, 0);
    else                chk(upd_rd == 1'b1, "R4", upd_rd, 1);
    if (coll) rd_addr = a;
    if (a < 10'(DEPTH)) ref_mem[a] = p;
    if (coll) begin
      @(negedge clk);
      chk(rd_data == old, "R6", rd_data, old);
      chk(upd_rd == 1'b1, "R3", upd_rd, 1);
      @(negedge clk);
      chk(rd_data == ref_read(a), "R6", rd_data, ref_read(a));
    end
  endtask

  task automatic pred_chk(input bit v, input logic [3:0] d, input bit f);
    @(negedge clk);
    pred_valid = v; pred = d; pred_full = f;
    #1;
    chk(pred_push == (v && !f), "R8", pred_push, int'(v && !f));
    if (v && !f) chk(pred_data == d, "R8", pred_data, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(upd_rd == 1'b1, "R1", upd_rd, 1);
    chk(pred_push == 1'b0, "R8", pred_push, 0);
    // R1: whole buffer cleared
    for (int i = 0; i < DEPTH; i++) read_chk(10'(i), "R1");

    // R3/R5 directed stores
    push(10'd0, 8'hA5, 1'b0);
    push(10'd783, 8'h3C, 1'b0);
    read_chk(10'd0, "R5");
    read_chk(10'd783, "R5");
    // R4 discard, then neighbouring and aliased locations untouched
    push(10'd784, 8'hFF, 1'b0);
    push(10'd1000, 8'h77, 1'b0);
    push(10'd1023, 8'h11, 1'b1);
    read_chk(10'd216, "R4");
    read_chk(10'd0, "R4");
    read_chk(10'd783, "R4");
    // R7 out-of-range reads
    read_chk(10'd784, "R7");
    read_chk(10'd1023, "R7");
    // R6 collisions: old value then new
    push(10'd5, 8'h12, 1'b1);
    push(10'd5, 8'h34, 1'b1);
    push(10'd783, 8'h99, 1'b1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [9:0] a;
      a = ($urandom % 5 == 0) ? 10'(784 + $urandom % 240) : 10'($urandom % DEPTH);
      push(a, 8'($urandom), ($urandom % 4) == 0);
      if ($urandom % 3 == 0) read_chk(10'($urandom), "R5");
    end
    for (int i = 0; i < DEPTH; i++) read_chk(10'(i), "R5");

    // R8 prediction gating
    pred_chk(1'b1, 4'd7, 1'b0);
    pred_chk(1'b1, 4'd9, 1'b1);
    pred_chk(1'b0, 4'd3, 1'b0);
    for (int n = 0; n < 60; n++) pred_chk(1'($urandom), 4'($urandom), 1'($urandom));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule